// File: doc/BRIEF.md
# Constant-Aware Register Bank

This block is the architectural register storage of a small multi-cycle processor. It keeps sixteen 16-bit entries, each selected by a 4-bit index. It offers two independent combinational read ports and one write port that takes effect on the clock edge. Instruction decode, the ALU, memory access and the sequencer all sit outside the block. They drive the indices and strobes and consume the read data.

Two indices are hard-wired constants and are never stored: index 1 returns all zeros and index 2 returns all ones. Index 14 holds the stack pointer, which is an ordinary stored entry. Index 15 holds the instruction pointer, the address of the next instruction. The sequencer can advance it by one or load a jump target through dedicated strobes, without using the general write port. The instruction pointer value is also driven onto a dedicated output for instruction fetch.

There is no data stream at this block's edge. Every pin is a plain control or data pin that is sampled each cycle, with no valid/ready handshake and therefore no back-pressure.

Top module: `reg_bank_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, every stored entry becomes 0x0000. This includes index 0, indices 3 to 14 and the instruction pointer at index 15.
- R2: Index 1 reads 0x0000 on both read ports at all times. A write addressed to index 1 changes nothing.
- R3: Index 2 reads 0xFFFF on both read ports at all times. A write addressed to index 2 changes nothing.
- R4: For indices 0 and 3 to 15, a write with `wr_en` high stores `wr_data`. From the cycle after the edge, both read ports return that value.
- R5: Reads are combinational. In the cycle where a write to the same index is pending, a read returns the value held before that write.
- R6: `ip_inc` alone adds 1 to the instruction pointer at the edge. The value wraps from 0xFFFF to 0x0000.
- R7: `ip_load` stores `ip_load_data` into the instruction pointer. When `ip_load` and `ip_inc` are both high, the load wins.
- R8: A general write to index 15 takes priority over both `ip_load` and `ip_inc` in the same cycle.
- R9: `ip_value` always equals what a read port returns for index 15.
- R10: With `wr_en`, `ip_load` and `ip_inc` all low, no entry changes, whatever `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 16 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | General write strobe |
| wr_idx | input | 4 | General write index |
| wr_data | input | 16 | General write data |
| ip_inc | input | 1 | Advance instruction pointer by one |
| ip_load | input | 1 | Load instruction pointer from ip_load_data |
| ip_load_data | input | 16 | Jump target for the instruction pointer |
| ip_value | output | 16 | Current instruction pointer |

## Verification
The bench attacks the cases described below, each of which a faulty design would get wrong in a visible way.

- **Constant entries after a write.** A design that forgot the constant rule would echo the value written to index 1 or 2.
- **Same-cycle read during a write.** A design that bypassed write data onto the read path would show the new value one cycle early.
- **Instruction pointer priority.** All three sources are driven at once, so an inverted priority yields the load target or an incremented value instead of the written word.
- **Wrap at the top.** An increment from 0xFFFF must give 0x0000.
- **Write enable low.** A write with the enable low must leave the target untouched, which exposes any decode that ignores `wr_en`.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DATA_W   = 16;
  parameter int unsigned RF_ADDR_W   = 4;
  parameter int unsigned RF_ZERO_IDX = 1;
  parameter int unsigned RF_ONES_IDX = 2;
  parameter int unsigned RF_SP_IDX   = 14;
  parameter int unsigned RF_IP_IDX   = 15;
endpackage

// File: rtl/rf_gp_reg.sv
module rf_gp_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/rf_ip_reg.sv
module rf_ip_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_we,
  input  logic [DATA_W-1:0] gen_d,
  input  logic              load,
  input  logic [DATA_W-1:0] load_d,
  input  logic              inc,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // priority: general write, then jump load, then increment
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (gen_we) q <= gen_d;
    else if (load)   q <= load_d;
    else if (inc)    q <= q + ONE;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 2 ** ADDR_W
) (
  input  logic [DATA_W-1:0] ents [DEPTH],
  input  logic [ADDR_W-1:0] idx,
  output logic [DATA_W-1:0] data
);
  assign data = ents[idx];
endmodule

// File: rtl/reg_bank_top.sv
module reg_bank_top
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W   = RF_DATA_W,
  parameter int unsigned ADDR_W   = RF_ADDR_W,
  parameter int unsigned ZERO_IDX = RF_ZERO_IDX,
  parameter int unsigned ONES_IDX = RF_ONES_IDX,
  parameter int unsigned IP_IDX   = RF_IP_IDX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ip_inc,
  input  logic              ip_load,
  input  logic [DATA_W-1:0] ip_load_data,
  output logic [DATA_W-1:0] ip_value
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] ents [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == ZERO_IDX) begin : g_zero
      assign ents[i] = '0;
    end else if (i == ONES_IDX) begin : g_ones
      assign ents[i] = '1;
    end else if (i == IP_IDX) begin : g_ip
      rf_ip_reg #(.DATA_W(DATA_W)) u_ip (
        .clk    (clk),
        .rst    (rst),
        .gen_we (wr_en && (wr_idx == ADDR_W'(i))),
        .gen_d  (wr_data),
        .load   (ip_load),
        .load_d (ip_load_data),
        .inc    (ip_inc),
        .q      (ents[i])
      );
    end else begin : g_gp
      rf_gp_reg #(.DATA_W(DATA_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .we  (wr_en && (wr_idx == ADDR_W'(i))),
        .d   (wr_data),
        .q   (ents[i])
      );
    end
  end

  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .ents (ents), .idx (rd_a_idx), .data (rd_a_data)
  );
  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .ents (ents), .idx (rd_b_idx), .data (rd_b_data)
  );

  assign ip_value = ents[IP_IDX];
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned ADDR_W = RF_ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              ip_inc,
  input logic              ip_load,
  input logic [DATA_W-1:0] ip_load_data,
  input logic [DATA_W-1:0] ip_value
);
  localparam logic [ADDR_W-1:0] Z_I  = ADDR_W'(RF_ZERO_IDX);
  localparam logic [ADDR_W-1:0] O_I  = ADDR_W'(RF_ONES_IDX);
  localparam logic [ADDR_W-1:0] IP_I = ADDR_W'(RF_IP_IDX);

  logic gen_ip_wr;
  assign gen_ip_wr = wr_en && (wr_idx == IP_I);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ip_value == '0));

  a_r2_zero_entry: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == Z_I) |-> (rd_b_data == '0));

  a_r3_ones_entry: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == O_I) |-> (rd_a_data == '1));

  a_r4_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != Z_I && wr_idx != O_I) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

  a_r6_ip_increment: assert property (@(posedge clk) disable iff (rst)
    (ip_inc && !ip_load && !gen_ip_wr) |=>
      (ip_value == $past(ip_value) + DATA_W'(1)));

  a_r7_load_over_inc: assert property (@(posedge clk) disable iff (rst)
    (ip_load && !gen_ip_wr) |=> (ip_value == $past(ip_load_data)));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    gen_ip_wr |=> (ip_value == $past(wr_data)));

  a_r9_ip_matches_read: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == IP_I) |-> (rd_b_data == ip_value));

  a_r10_idle_ip_hold: assert property (@(posedge clk) disable iff (rst)
    (!ip_inc && !ip_load && !wr_en) |=> $stable(ip_value));
endmodule

bind reg_bank_top rf_checker u_rf_checker (.*);

// File: tb/tb_reg_bank_top.sv
module tb_reg_bank_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data, ip_load_data, ip_value;
  logic        wr_en, ip_inc, ip_load;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reg_bank_top dut (.*);

  // write index, write data, expected readback
  localparam int NV = 8;
  localparam logic [3:0]  V_IDX [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd9, 4'd13, 4'd14, 4'd15};
  localparam logic [15:0] V_DAT [NV] = '{16'h1234, 16'hABCD, 16'h0000, 16'h5555,
                                          16'hAAAA, 16'h0F0F, 16'h8000, 16'h7FFF};
  localparam logic [15:0] V_EXP [NV] = '{16'h1234, 16'h0000, 16'hFFFF, 16'h5555,
                                          16'hAAAA, 16'h0F0F, 16'h8000, 16'h7FFF};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; ip_inc = 1'b0; ip_load = 1'b0;
  endtask

  // drive at negedge, one posedge acts, sample at next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle();
    wr_idx = '0; wr_data = '0; ip_load_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    // make entries nonzero before reset to prove clearing
    @(negedge clk); rst = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 16'hDEAD; ip_inc = 1'b1;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    // R1 reset state
    rd_a_idx = 4'd5; rd_b_idx = 4'd0; #1;
    check("R1 entry5", rd_a_data, 16'h0000);
    check("R1 entry0", rd_b_data, 16'h0000);
    check("R1 ip", ip_value, 16'h0000);
    rd_a_idx = 4'd1; rd_b_idx = 4'd2; #1;
    check("R2 reset", rd_a_data, 16'h0000);
    check("R3 reset", rd_b_data, 16'hFFFF);

    // vector table: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = V_IDX[i]; wr_data = V_DAT[i];
      step();
      rd_a_idx = V_IDX[i]; rd_b_idx = V_IDX[i]; #1;
      check("R4 table port A", rd_a_data, V_EXP[i]);
      check("R4 table port B", rd_b_data, V_EXP[i]);
    end
    check("R9 ip after table", ip_value, 16'h7FFF);
    rd_b_idx = 4'd15; #1;
    check("R9 read port", rd_b_data, ip_value);

    // R5 read old value during pending write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'h1111; rd_a_idx = 4'd3; #1;
    check("R5 old value", rd_a_data, 16'h5555);
    step(); #1;
    check("R5 new value", rd_a_data, 16'h1111);

    // R10 write enable low
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd3; wr_data = 16'h9999;
    step(); rd_a_idx = 4'd3; #1;
    check("R10 no change", rd_a_data, 16'h1111);
    check("R10 ip hold", ip_value, 16'h7FFF);

    // R6 increment and wrap
    @(negedge clk); ip_inc = 1'b1; step();
    check("R6 inc", ip_value, 16'h8000);
    @(negedge clk); ip_load = 1'b1; ip_load_data = 16'hFFFF; step();
    check("R7 load", ip_value, 16'hFFFF);
    @(negedge clk); ip_inc = 1'b1; step();
    check("R6 wrap", ip_value, 16'h0000);

    // R7 load beats increment
    @(negedge clk); ip_inc = 1'b1; ip_load = 1'b1; ip_load_data = 16'h0400; step();
    check("R7 load over inc", ip_value, 16'h0400);

    // R8 general write beats load and increment
    @(negedge clk);
    ip_inc = 1'b1; ip_load = 1'b1; ip_load_data = 16'h0222;
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 16'h0C0C;
    step();
    check("R8 write wins", ip_value, 16'h0C0C);
    rd_a_idx = 4'd15; #1;
    check("R9 port A ip", rd_a_data, 16'h0C0C);

    // R2/R3 write both constants with same data, read both ports
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd1; wr_data = 16'h5A5A; step();
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd2; wr_data = 16'h5A5A; step();
    rd_a_idx = 4'd2; rd_b_idx = 4'd1; #1;
    check("R3 after write", rd_a_data, 16'hFFFF);
    check("R2 after write", rd_b_data, 16'h0000);
    rd_a_idx = 4'd14; #1;
    check("R4 stack ptr kept", rd_a_data, 16'h8000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule